// File: doc/BRIEF.md
# Configurable Multi-Output Logic Cell Group

This block is a row of identical logic cells. Each cell takes four single-bit sum-of-products terms, called A, B, C and D, from an external logic array. It owns one storage bit that can act as a D, T or JK flip-flop, and it drives three registered outputs. A static configuration word sets, per cell, what each sum term does. A can be data, B can be K or a preset, C can be a clock or a reset, and D can be a clock or an enable or feedback term. The same word picks the clock source and the clock polarity, and chooses what each output shows.

All cells share a set of global controls: a system clock, a preset, a reset and a register-type override. While the override is high, every T or JK cell behaves as a D cell. A counter built from several cells can therefore load a value in D mode and count in T mode without extra load terms.

The whole group runs in one fabric clock domain `clk`. The system clock and the sum-term clocks are sampled as data. A storage update happens in the `clk` cycle where the selected source shows the selected edge.

Top module: `lcell_group`

## Requirements
- R1: While `rst` is high, and in the cycle after it, all outputs and all storage bits read 0. The configuration word of each cell is captured while `rst` is high.
- R2: After `rst` falls, changes on `cfg_in` have no effect until the next reset.
- R3: Mode field `cfg[1:0]` selects the register type: 0 or 3 is D, 1 is T, 2 is JK. In D mode, a clock event loads Sum-A into the storage bit.
- R4: In T mode, a clock event toggles the storage bit when Sum-A is 1 and holds it when Sum-A is 0.
- R5: In JK mode, with J = Sum-A and K = Sum-B, a clock event gives the following J/K results: 1/1 toggles, 0/0 holds, 1/0 sets, 0/1 clears.
- R6: While `g_regtype` is high, a cell configured as T or JK behaves as a D cell for that clock event.
- R7: Clock source field `cfg[3:2]` equal to 0 or 3 selects `sys_clk`. Bit `cfg[4]` picks the edge: 0 for rising, 1 for falling. An edge is detected against the value sampled in the previous `clk` cycle, and that value is taken as 0 after reset. With no clock event, no preset and no reset, the storage bit holds.
- R8: Clock source 1 clocks the cell on a rising Sum-C. Clock source 2 clocks the cell on a rising Sum-D. Each is detected against the previous `clk` cycle.
- R9: Bit `cfg[5]` makes Sum-B a preset, and K is then 0. Bit `cfg[6]` makes Sum-C a reset, unless Sum-C is the clock. Local and global presets are ORed together, and so are local and global resets. Reset beats preset, and both beat any clock event.
- R10: `out_io` selects by `cfg[8:7]` and `out_aux` selects by `cfg[10:9]`. The codes are 0 = storage bit, 1 = Sum-A, 2 = Sum-B, 3 = Sum-C. Each output is registered and shows, one `clk` after a cycle, the new storage value or the sum term sampled in that cycle.
- R11: `out_oe` shows Sum-D when `cfg[11]` is 0 and the storage bit when `cfg[11]` is 1, with the same timing as R10.
- R12: The global clock, preset, reset and register-type inputs act on every cell at once. A 10-bit counter of T cells loads through `g_regtype` and then counts, including wrap-around.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fabric clock |
| rst | input | 1 | Synchronous active-high reset; configuration capture window |
| sys_clk | input | 1 | Global system clock, sampled as data |
| g_regtype | input | 1 | Global override forcing T/JK cells to D |
| g_preset | input | 1 | Global preset |
| g_reset | input | 1 | Global reset |
| cfg_in | input | NCELL*12 | Per-cell configuration words, cell i at bits [12i+11:12i] |
| sum_a | input | NCELL | Sum term A per cell |
| sum_b | input | NCELL | Sum term B per cell |
| sum_c | input | NCELL | Sum term C per cell |
| sum_d | input | NCELL | Sum term D per cell |
| out_io | output | NCELL | First selectable output per cell |
| out_aux | output | NCELL | Second selectable output per cell |
| out_oe | output | NCELL | Enable or buried feedback output per cell |

## Verification
The assertions check four things on every cycle. Reset clears the outputs and the storage. A global reset empties every storage bit, and a global preset fills them when no local reset is active. A storage bit holds whenever there is no system clock change, no sum-term activity and no global control. Only the bench scenarios can show the rest. These are the per-mode next-state rules, the effect of the clock source and polarity, the output selection codes, the freezing of the configuration after reset, and the load-then-count sequence of the 10-bit counter. The bench compares all of these against a behavioural model on every clock.

// File: rtl/lcell_pkg.sv
package lcell_pkg;

  typedef enum logic [1:0] {RM_D = 2'd0, RM_T = 2'd1, RM_JK = 2'd2, RM_D2 = 2'd3} regmode_e;
  typedef enum logic [1:0] {CK_SYS = 2'd0, CK_SUMC = 2'd1, CK_SUMD = 2'd2, CK_SYS2 = 2'd3} cksrc_e;
  typedef enum logic [1:0] {OS_Q = 2'd0, OS_A = 2'd1, OS_B = 2'd2, OS_C = 2'd3} osel_e;

  // Per-cell configuration word, bit 11 down to bit 0.
  typedef struct packed {
    logic     oe_from_q;  // [11]
    osel_e    aux_sel;    // [10:9]
    osel_e    io_sel;     // [8:7]
    logic     c_reset;    // [6]
    logic     b_preset;   // [5]
    logic     sys_fall;   // [4]
    cksrc_e   cksrc;      // [3:2]
    regmode_e mode;       // [1:0]
  } cfg_t;

  localparam int CFG_W = $bits(cfg_t);

  function automatic logic osel_pick(osel_e s, logic q, logic a, logic b, logic c);
    case (s)
      OS_Q:    return q;
      OS_A:    return a;
      OS_B:    return b;
      default: return c;
    endcase
  endfunction

endpackage

// File: rtl/lcell_gedge.sv
module lcell_gedge (
  input  logic clk,
  input  logic rst,
  input  logic sys_clk,
  output logic sys_rise,
  output logic sys_fall
);
  logic prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= sys_clk;
  end

  assign sys_rise = sys_clk & ~prev_q;
  assign sys_fall = ~sys_clk & prev_q;
endmodule

// File: rtl/lcell_route.sv
module lcell_route
  import lcell_pkg::*;
(
  input  cfg_t     cfg,
  input  logic     g_regtype,
  input  logic     g_preset,
  input  logic     g_reset,
  input  logic     sys_rise,
  input  logic     sys_fall,
  input  logic     a,
  input  logic     b,
  input  logic     c,
  input  logic     d,
  input  logic     prev_c,
  input  logic     prev_d,
  output logic     tick,
  output regmode_e mode,
  output logic     j,
  output logic     k,
  output logic     set,
  output logic     clr
);
  logic c_is_clock;

  always_comb begin
    c_is_clock = (cfg.cksrc == CK_SUMC);
    unique case (cfg.cksrc)
      CK_SUMC: tick = c & ~prev_c;
      CK_SUMD: tick = d & ~prev_d;
      default: tick = cfg.sys_fall ? sys_fall : sys_rise;
    endcase
    if (g_regtype || cfg.mode == RM_D2) mode = RM_D;
    else                                mode = cfg.mode;
    j   = a;
    k   = cfg.b_preset ? 1'b0 : b;
    set = g_preset | (cfg.b_preset & b);
    clr = g_reset  | (cfg.c_reset & ~c_is_clock & c);
  end
endmodule

// File: rtl/lcell_store.sv
module lcell_store
  import lcell_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     tick,
  input  regmode_e mode,
  input  logic     j,
  input  logic     k,
  input  logic     set,
  input  logic     clr,
  output logic     q,
  output logic     q_nxt
);
  always_comb begin
    q_nxt = q;
    if (clr)       q_nxt = 1'b0;
    else if (set)  q_nxt = 1'b1;
    else if (tick) begin
      unique case (mode)
        RM_T:  q_nxt = q ^ j;
        RM_JK: begin
          unique case ({j, k})
            2'b11:   q_nxt = ~q;
            2'b10:   q_nxt = 1'b1;
            2'b01:   q_nxt = 1'b0;
            default: q_nxt = q;
          endcase
        end
        default: q_nxt = j;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) q <= 1'b0;
    else     q <= q_nxt;
  end
endmodule

// File: rtl/lcell_cell.sv
module lcell_cell
  import lcell_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  cfg_t cfg_in,
  input  logic g_regtype,
  input  logic g_preset,
  input  logic g_reset,
  input  logic sys_rise,
  input  logic sys_fall,
  input  logic a,
  input  logic b,
  input  logic c,
  input  logic d,
  output logic q,
  output logic o_io,
  output logic o_aux,
  output logic o_oe
);
  cfg_t     cfg_q;
  logic     prev_c, prev_d;
  logic     tick, j, k, set, clr, q_nxt;
  regmode_e mode;

  always_ff @(posedge clk) begin
    if (rst) cfg_q <= cfg_in;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_c <= 1'b0;
      prev_d <= 1'b0;
    end else begin
      prev_c <= c;
      prev_d <= d;
    end
  end

  lcell_route u_route (
    .cfg(cfg_q), .g_regtype(g_regtype), .g_preset(g_preset), .g_reset(g_reset),
    .sys_rise(sys_rise), .sys_fall(sys_fall),
    .a(a), .b(b), .c(c), .d(d), .prev_c(prev_c), .prev_d(prev_d),
    .tick(tick), .mode(mode), .j(j), .k(k), .set(set), .clr(clr)
  );

  lcell_store u_store (
    .clk(clk), .rst(rst), .tick(tick), .mode(mode), .j(j), .k(k),
    .set(set), .clr(clr), .q(q), .q_nxt(q_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      o_io  <= 1'b0;
      o_aux <= 1'b0;
      o_oe  <= 1'b0;
    end else begin
      o_io  <= osel_pick(cfg_q.io_sel,  q_nxt, a, b, c);
      o_aux <= osel_pick(cfg_q.aux_sel, q_nxt, a, b, c);
      o_oe  <= cfg_q.oe_from_q ? q_nxt : d;
    end
  end
endmodule

// File: rtl/lcell_group.sv
module lcell_group
  import lcell_pkg::*;
#(
  parameter int NCELL = 10
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   sys_clk,
  input  logic                   g_regtype,
  input  logic                   g_preset,
  input  logic                   g_reset,
  input  logic [NCELL*CFG_W-1:0] cfg_in,
  input  logic [NCELL-1:0]       sum_a,
  input  logic [NCELL-1:0]       sum_b,
  input  logic [NCELL-1:0]       sum_c,
  input  logic [NCELL-1:0]       sum_d,
  output logic [NCELL-1:0]       out_io,
  output logic [NCELL-1:0]       out_aux,
  output logic [NCELL-1:0]       out_oe
);
  logic             sys_rise, sys_fall;
  logic [NCELL-1:0] q_all;

  lcell_gedge u_gedge (
    .clk(clk), .rst(rst), .sys_clk(sys_clk), .sys_rise(sys_rise), .sys_fall(sys_fall)
  );

  for (genvar g = 0; g < NCELL; g++) begin : g_cell
    lcell_cell u_cell (
      .clk(clk), .rst(rst),
      .cfg_in(cfg_t'(cfg_in[g*CFG_W +: CFG_W])),
      .g_regtype(g_regtype), .g_preset(g_preset), .g_reset(g_reset),
      .sys_rise(sys_rise), .sys_fall(sys_fall),
      .a(sum_a[g]), .b(sum_b[g]), .c(sum_c[g]), .d(sum_d[g]),
      .q(q_all[g]), .o_io(out_io[g]), .o_aux(out_aux[g]), .o_oe(out_oe[g])
    );
  end
endmodule

// File: rtl/lcell_group_chk.sv
module lcell_group_chk #(
  parameter int NCELL = 10
) (
  input logic             clk,
  input logic             rst,
  input logic             sys_clk,
  input logic             g_preset,
  input logic             g_reset,
  input logic [NCELL-1:0] sum_b,
  input logic [NCELL-1:0] sum_c,
  input logic [NCELL-1:0] sum_d,
  input logic [NCELL-1:0] q_all,
  input logic [NCELL-1:0] out_io,
  input logic [NCELL-1:0] out_aux,
  input logic [NCELL-1:0] out_oe
);
  // R1
  rst_clears_chk: assert property (@(posedge clk)
    rst |=> (out_io == '0 && out_aux == '0 && out_oe == '0 && q_all == '0));

  // R9
  reset_dominates_chk: assert property (@(posedge clk) disable iff (rst)
    g_reset |=> (q_all == '0));

  // R12
  preset_fills_chk: assert property (@(posedge clk) disable iff (rst)
    (g_preset && !g_reset && sum_c == '0) |=> (q_all == '1));

  // R7
  hold_no_event_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && sys_clk == $past(sys_clk) && !g_preset && !g_reset &&
     sum_b == '0 && sum_c == '0 && sum_d == '0) |=> $stable(q_all));
endmodule

bind lcell_group lcell_group_chk #(.NCELL(NCELL)) u_chk (
  .clk(clk), .rst(rst), .sys_clk(sys_clk), .g_preset(g_preset), .g_reset(g_reset),
  .sum_b(sum_b), .sum_c(sum_c), .sum_d(sum_d), .q_all(q_all),
  .out_io(out_io), .out_aux(out_aux), .out_oe(out_oe)
);

// File: tb/lcell_group_bench.sv
module lcell_group_bench;
  localparam int N  = 10;
  localparam int CW = 12;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sys_clk = 1'b0, g_regtype = 1'b0, g_preset = 1'b0, g_reset = 1'b0;
  logic [N*CW-1:0] cfg_in = '0;
  logic [N-1:0] sum_a = '0, sum_b = '0, sum_c = '0, sum_d = '0;
  logic [N-1:0] out_io, out_aux, out_oe;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  string tag = "R1";

  always #5 clk = ~clk;

  lcell_group #(.NCELL(N)) u_lcell_group (
    .clk(clk), .rst(rst), .sys_clk(sys_clk), .g_regtype(g_regtype),
    .g_preset(g_preset), .g_reset(g_reset), .cfg_in(cfg_in),
    .sum_a(sum_a), .sum_b(sum_b), .sum_c(sum_c), .sum_d(sum_d),
    .out_io(out_io), .out_aux(out_aux), .out_oe(out_oe)
  );

  // Behavioural reference model
  logic [CW-1:0] mcfg [N];
  bit mq [N], mpc [N], mpd [N];
  bit mg = 0;
  logic [N-1:0] e_io = '0, e_aux = '0, e_oe = '0;

  function automatic bit pick(int s, bit q, bit a, bit b, bit c);
    if (s == 0) return q;
    if (s == 1) return a;
    if (s == 2) return b;
    return c;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < N; i++) begin
        mcfg[i] = cfg_in[i*CW +: CW];
        mq[i] = 0; mpc[i] = 0; mpd[i] = 0;
      end
      e_io = '0; e_aux = '0; e_oe = '0;
      mg = 0;
    end else begin
      bit rise, fall;
      rise = sys_clk && !mg;
      fall = !sys_clk && mg;
      for (int i = 0; i < N; i++) begin
        int md, cs;
        bit a, b, c, d, tk, kk, st, cl, nq;
        a = sum_a[i]; b = sum_b[i]; c = sum_c[i]; d = sum_d[i];
        md = int'(mcfg[i][1:0]);
        cs = int'(mcfg[i][3:2]);
        if (md == 3 || g_regtype) md = 0;
        if (cs == 1)      tk = c && !mpc[i];
        else if (cs == 2) tk = d && !mpd[i];
        else              tk = mcfg[i][4] ? fall : rise;
        kk = mcfg[i][5] ? 1'b0 : b;
        st = g_preset || (mcfg[i][5] && b);
        cl = g_reset || (mcfg[i][6] && cs != 1 && c);
        nq = mq[i];
        if (cl) nq = 0;
        else if (st) nq = 1;
        else if (tk) begin
          if (md == 0) nq = a;
          else if (md == 1) nq = a ? !mq[i] : mq[i];
          else begin
            if (a && kk) nq = !mq[i];
            else if (a) nq = 1;
            else if (kk) nq = 0;
          end
        end
        e_io[i]  = pick(int'(mcfg[i][8:7]),  nq, a, b, c);
        e_aux[i] = pick(int'(mcfg[i][10:9]), nq, a, b, c);
        e_oe[i]  = mcfg[i][11] ? nq : d;
        mq[i] = nq; mpc[i] = c; mpd[i] = d;
      end
      mg = sys_clk;
    end
  end

  task automatic compare();
    checks++;
    if (out_io !== e_io || out_aux !== e_aux || out_oe !== e_oe) begin
      fails++;
      $display("FAIL %s: io/aux/oe actual %h/%h/%h expected %h/%h/%h",
               tag, out_io, out_aux, out_oe, e_io, e_aux, e_oe);
    end
  endtask

  task automatic cycle();
    @(posedge clk);
    @(negedge clk);
    compare();
  endtask

  task automatic check_val(string t, logic [N-1:0] act, logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", t, act, exp);
    end
  endtask

  task automatic randomize_inputs();
    logic [31:0] r;
    r = $urandom; sum_a = r[N-1:0];
    r = $urandom; sum_b = r[N-1:0];
    r = $urandom; sum_c = r[N-1:0];
    r = $urandom; sum_d = r[N-1:0];
    if ($urandom % 2 == 0) sys_clk = ~sys_clk;
    g_regtype = ($urandom % 4 == 0);
    g_preset  = ($urandom % 16 == 0);
    g_reset   = ($urandom % 16 == 0);
  endtask

  task automatic random_cfg();
    for (int i = 0; i < N; i++) begin
      logic [31:0] r;
      r = $urandom;
      cfg_in[i*CW +: CW] = r[CW-1:0];
    end
  endtask

  task automatic clear_inputs();
    sum_a = '0; sum_b = '0; sum_c = '0; sum_d = '0;
    sys_clk = 0; g_regtype = 0; g_preset = 0; g_reset = 0;
  endtask

  task automatic do_reset();
    rst = 1;
    cycle();
    cycle();
    rst = 0;
  endtask

  // Toggle terms for a binary up-counter of T cells
  function automatic logic [N-1:0] toggles(logic [N-1:0] v);
    logic [N-1:0] t;
    t[0] = 1'b1;
    for (int i = 1; i < N; i++) t[i] = t[i-1] & v[i-1];
    return t;
  endfunction

  task automatic count_run(logic [N-1:0] load, int steps);
    logic [N-1:0] cnt;
    g_regtype = 1; sum_a = load; sys_clk = 1;
    cycle();
    check_val("R6 load", out_io, load);
    g_regtype = 0; sys_clk = 0;
    cycle();
    check_val("R7 hold on falling edge", out_io, load);
    cnt = load;
    for (int s = 0; s < steps; s++) begin
      sum_a = toggles(cnt);
      sys_clk = 1;
      cycle();
      cnt = cnt + 1'b1;
      check_val("R12 count", out_io, cnt);
      sys_clk = 0;
      cycle();
    end
  endtask

  initial begin
    // R1: reset state
    random_cfg();
    clear_inputs();
    rst = 1;
    tag = "R1";
    for (int i = 0; i < 3; i++) cycle();
    check_val("R1 out_io", out_io, '0);
    check_val("R1 out_oe", out_oe, '0);
    rst = 0;

    // Random configuration epochs covering R3 R4 R5 R7 R8 R9 R10 R11
    for (int e = 0; e < 30; e++) begin
      random_cfg();
      do_reset();
      tag = "R3 R4 R5 R7 R8 R9 R10 R11";
      for (int c = 0; c < 200; c++) begin
        if (c == 60) begin
          random_cfg();
          tag = "R2 R3 R4 R5 R8 R9 R10 R11";
        end
        randomize_inputs();
        cycle();
      end
    end

    // R6 / R12: 10-bit counter, T cells, io shows Q, aux shows Sum-A
    for (int i = 0; i < N; i++) cfg_in[i*CW +: CW] = 12'h201;
    clear_inputs();
    do_reset();
    tag = "R6 R12";
    count_run(10'h2A5, 7);
    count_run(10'h3FD, 5);

    // R9: reset beats preset, global preset fills all cells
    g_preset = 1; g_reset = 1;
    cycle();
    check_val("R9 reset over preset", out_io, '0);
    g_reset = 0;
    cycle();
    check_val("R9 R12 global preset", out_io, '1);
    g_preset = 0;
    cycle();
    check_val("R11 oe shows Sum-D", out_oe, '0);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule